// File: doc/BRIEF.md
# Shared-Enable Pipeline Flow Controller

This block runs the flow control for a fixed-depth datapath whose stage registers live outside it and all advance on one common enable. It accepts items through a valid/ready handshake on its input side and offers them through a valid/ready handshake on its output side. Internally it keeps only one occupancy flag per stage, in a shift chain that moves whenever the shared enable is high. It never holds payload itself.

The consumer side decides whether the whole pipe may move. The pipe advances when the last stage is empty or the consumer is taking its item. A chip-enable input freezes the whole pipe. While chip-enable is low, the output valid is also held low, so that no consumer can take an item that the pipe is not shifting out. The ready sent upstream is the shared enable itself, so an input item is captured exactly when the external stage-0 register loads it.

Top module: `stall_pipe_ctrl`

## Requirements
- R1: While the synchronous reset is active (low, with the default polarity), every occupancy flag is cleared. In the first cycle after reset, `dn_valid` is 0.
- R2: With `ce` high, `enable` is 1 exactly when `dn_valid` is 0 or `dn_ready` is 1. This is decided in the same cycle, with no register in the path.
- R3: `up_ready` carries the same value as `enable` in every cycle.
- R4: With `enable` low, all occupancy flags keep their values. An item shown on `dn_valid` stays shown, with unchanged external data, until it is taken.
- R5: On each rising edge with `enable` high, stage 0 captures `up_valid` and every other stage takes the flag of the stage before it. An item accepted on one enabled edge leaves on the enabled edge exactly `STAGES` enabled edges later.
- R6: While `ce` is low, `enable`, `up_ready` and `dn_valid` are all 0.
- R7: The items leaving through the downstream handshake are exactly the accepted items, in acceptance order, with none lost and none repeated.
- R8: A downstream transfer (`dn_valid` and `dn_ready` both 1) only happens in a cycle where `enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset; active level set by `RST_ACTIVE_LOW` (default active-low) |
| ce | input | 1 | Chip enable, active high; low freezes the pipe |
| up_valid | input | 1 | Upstream producer offers an item |
| up_ready | output | 1 | Pipe accepts an item this cycle (equal to `enable`) |
| dn_valid | output | 1 | Last stage holds an item and `ce` is high |
| dn_ready | input | 1 | Downstream consumer takes the offered item |
| enable | output | 1 | Shared load enable for all external stage registers |

## Verification
The bench builds the block with its defaults: three stages and an active-low reset. With three stages, every occupancy pattern of a short pipe occurs, including a full pipe that is stalled, bubbles in the middle, and items that stay in place across chip-enable gaps. The external stage registers are modelled as a three-deep shift register driven by `enable`. Random producer and consumer patterns with frequent chip-enable gaps then reach every stall and bubble combination, while the scoreboard checks ordering and the exact enabled-edge latency.

// File: rtl/stall_pipe_pkg.sv
// Package: stall_pipe_pkg
// Shared helpers for the shared-enable pipeline flow controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package stall_pipe_pkg;

    // Translate the raw reset pin into an "is active" flag for a given polarity.
    function automatic logic reset_asserted(input logic rst_pin, input bit active_low);
        return active_low ? ~rst_pin : rst_pin;
    endfunction

    // Smallest legal stage count.
    localparam int MIN_STAGES = 1;

endpackage

// File: rtl/stall_pipe_vld_chain.sv
// Module: stall_pipe_vld_chain
// Holds one occupancy flag per pipeline stage. On a clock edge with
// shift_en high, stage 0 captures load_bit and each later stage takes the
// flag of its predecessor; otherwise all flags hold.
// Assumes: synchronous reset (rst_act already polarity-resolved).
module stall_pipe_vld_chain #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_act,
    input  logic              shift_en,
    input  logic              load_bit,
    output logic [STAGES-1:0] vld_q
);
    localparam int LAST = STAGES - 1;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic src;
            logic flag_q;

            if (s == 0) begin : g_head
                // Stage 0 is fed from the upstream valid.
                assign src = load_bit;
            end else begin : g_body
                // Later stages are fed from the previous stage.
                assign src = vld_q[s-1];
            end

            // Per-stage flag: clear on reset, move on shift, else hold.
            always_ff @(posedge clk) begin
                if (rst_act) begin
                    flag_q <= 1'b0;
                end else if (shift_en) begin
                    flag_q <= src;
                end
            end

            assign vld_q[s] = flag_q;
        end
    endgenerate

    // Elaboration-time sanity on depth.
    initial begin
        if (LAST < 0) $error("stall_pipe_vld_chain: STAGES must be at least 1");
    end
endmodule

// File: rtl/stall_pipe_flow.sv
// Module: stall_pipe_flow
// Combinational flow decision: the pipe may move when its tail is empty or
// the consumer takes the tail item; chip enable gates both the move and the
// visible downstream valid, so a frozen pipe never hands out an item.
// Assumes: tail_vld comes straight from the last occupancy flag.
module stall_pipe_flow (
    input  logic ce,
    input  logic tail_vld,
    input  logic dn_ready,
    output logic move,
    output logic dn_valid
);
    logic room;

    // Room exists when nothing sits at the tail or it leaves this cycle.
    always_comb begin
        room     = ~tail_vld | dn_ready;
        move     = room & ce;
        dn_valid = tail_vld & ce;
    end
endmodule

// File: rtl/stall_pipe_ctrl.sv
// Module: stall_pipe_ctrl (top)
// Flow controller for an external pipeline whose stage registers share one
// enable. Tracks stage occupancy only; drives the shared enable, which is
// also returned upstream as ready.
// Assumes: external stage registers load only when enable is high and all
// move together; reset is synchronous.
module stall_pipe_ctrl #(
    parameter int STAGES         = 3,
    parameter bit RST_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic up_valid,
    output logic up_ready,
    output logic dn_valid,
    input  logic dn_ready,
    output logic enable
);
    import stall_pipe_pkg::*;

    localparam int LAST = STAGES - 1;

    logic              rst_act;
    logic [STAGES-1:0] vld_q;
    logic              move;

    // Resolve reset polarity once for the whole block.
    assign rst_act = reset_asserted(rst_n, RST_ACTIVE_LOW);

    stall_pipe_vld_chain #(
        .STAGES(STAGES)
    ) chain_i (
        .clk      (clk),
        .rst_act  (rst_act),
        .shift_en (move),
        .load_bit (up_valid),
        .vld_q    (vld_q)
    );

    stall_pipe_flow flow_i (
        .ce       (ce),
        .tail_vld (vld_q[LAST]),
        .dn_ready (dn_ready),
        .move     (move),
        .dn_valid (dn_valid)
    );

    // Shared enable doubles as upstream ready.
    assign enable   = move;
    assign up_ready = move;
endmodule

// File: rtl/stall_pipe_ctrl_chk.sv
// Module: stall_pipe_ctrl_chk
// Property checker bound into every stall_pipe_ctrl instance.
// Assumes: rst_act is the polarity-resolved synchronous reset.
module stall_pipe_ctrl_chk #(
    parameter int STAGES = 3
) (
    input logic              clk,
    input logic              rst_act,
    input logic              ce,
    input logic              up_valid,
    input logic              enable,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [STAGES-1:0] vld_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst_act |=> (vld_q == '0));

    // R5
    head_load_chk: assert property (@(posedge clk) disable iff (rst_act)
        enable |=> (vld_q[0] == $past(up_valid)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
        !enable |=> $stable(vld_q));

    // R8
    drain_moves_chk: assert property (@(posedge clk) disable iff (rst_act)
        (dn_valid && dn_ready) |-> enable);

    // R6
    ce_freeze_chk: assert property (@(posedge clk) disable iff (rst_act)
        !ce |-> (!enable && !dn_valid));
endmodule

bind stall_pipe_ctrl stall_pipe_ctrl_chk #(
    .STAGES(STAGES)
) chk_i (
    .clk      (clk),
    .rst_act  (rst_act),
    .ce       (ce),
    .up_valid (up_valid),
    .enable   (enable),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .vld_q    (vld_q)
);

// File: tb/stall_pipe_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes accepted items into a queue, the
// monitor pops and compares at each downstream transfer. External stage
// registers are modelled as a shift register driven by enable.
module stall_pipe_ctrl_tb_top;
    localparam int STAGES = 3;
    localparam int DW     = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n, ce, up_valid, up_ready, dn_valid, dn_ready, enable;
    logic [DW-1:0] up_data;
    logic [DW-1:0] pipe_data [STAGES];
    logic [DW-1:0] dn_data;

    typedef struct {
        logic [DW-1:0] d;
        int            idx;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    en_cnt = 0;
    int    next_id = 1;
    bit    prev_hold = 0;
    logic [DW-1:0] prev_data = '0;
    bit    done = 0;

    stall_pipe_ctrl #(.STAGES(STAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .up_valid(up_valid), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .enable(enable)
    );

    // External data registers, advancing together on enable.
    always @(posedge clk) begin
        if (enable) begin
            pipe_data[0] <= up_data;
            for (int i = 1; i < STAGES; i++) pipe_data[i] <= pipe_data[i-1];
        end
    end
    assign dn_data = pipe_data[STAGES-1];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One cycle: drive after falling edge, sample before rising edge.
    task automatic step(input bit v, input bit r, input bit c);
        bit    en_s;
        item_t it;
        @(negedge clk);
        up_valid = v; dn_ready = r; ce = c; up_data = next_id[DW-1:0];
        #1;
        en_s = enable;
        if (!ce) begin
            // R6
            chk(!enable && !dn_valid && !up_ready, "R6", {enable, dn_valid}, 0);
        end else begin
            // R2
            chk(enable == (!dn_valid || dn_ready), "R2", enable, (!dn_valid || dn_ready));
            // R4: a stalled tail item stays, with unchanged data
            if (prev_hold) chk(dn_valid && dn_data == prev_data, "R4", dn_data, prev_data);
            prev_hold = dn_valid && !enable;
            prev_data = dn_data;
        end
        // R3
        chk(up_ready == enable, "R3", up_ready, enable);
        // Monitor
        if (dn_valid && dn_ready) begin
            chk(enable, "R8", enable, 1);
            if (exp_q.size() == 0) begin
                chk(0, "R7", dn_data, -1);
            end else begin
                it = exp_q.pop_front();
                chk(dn_data == it.d, "R7", dn_data, it.d);
                chk(en_cnt - it.idx == STAGES, "R5", en_cnt - it.idx, STAGES);
            end
        end
        // Driver bookkeeping
        if (up_valid && enable) begin
            exp_q.push_back('{d: up_data, idx: en_cnt});
            next_id++;
        end
        @(posedge clk);
        if (en_s) en_cnt++;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        rst_n = 1'b0; ce = 1'b0; up_valid = 1'b0; dn_ready = 1'b0; up_data = '0;
        for (int i = 0; i < STAGES; i++) pipe_data[i] = '0;
        repeat (3) @(negedge clk);
        ce = 1'b1; up_valid = 1'b1;
        #1;
        // R1: flags cleared while reset held
        chk(dn_valid == 0, "R1", dn_valid, 0);
        @(negedge clk);
        rst_n = 1'b1; up_valid = 1'b0;
        #1;
        // R1: first cycle after reset
        chk(dn_valid == 0, "R1", dn_valid, 0);
        chk(enable == 1, "R2", enable, 1);

        // Full throughput
        for (int k = 0; k < 40; k++) step(1, 1, 1);
        // Fill and stall with consumer blocked
        for (int k = 0; k < 10; k++) step(1, 0, 1);
        // Chip-enable gap during a full stall
        for (int k = 0; k < 5; k++) step(1, 1, 0);
        for (int k = 0; k < 6; k++) step(0, 1, 1);
        // Random traffic with chip-enable gaps
        for (int k = 0; k < 4000; k++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                 $urandom_range(0, 5) != 0);
        // Drain
        for (int k = 0; k < STAGES + 4; k++) step(0, 1, 1);
        // R7: nothing lost
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
        summary();
    end
endmodule